// File: doc/BRIEF.md
# Stripmined Partial-Sum Reducer

This block adds up an integer stream of any length. The stream arrives as chunks of `LANES` words, and the block keeps one partial sum per lane. Every accepted chunk adds its word in lane `i` into partial `i`, so a long stream is folded into `LANES` running totals without a serial carry chain through every element. The chunk flagged as last may be short. Its lanes at or above the given count are treated as zero.

Once the last chunk is in, the block stops taking input and collapses the partials in a tree. On each cycle it halves the active length `L` and adds partial `L+j` into partial `j` for every `j` below `L`. After `log2(LANES)` such cycles one value is left. That value is registered as the result, and `done` pulses for one cycle. The partials are cleared at the same time, ready for the next stream. All additions are 32-bit and wrap modulo 2^32.

Top module: `vec_reduce_unit`

## Requirements
- R1: While reset is high and on the first cycle after it, `busy` and `done` are 0 and `sum_out` is 0. Every partial starts at zero.
- R2: When `in_valid` is 1, `in_last` is 0 and `busy` is 0, every lane `i` (bits `i*32 +: 32` of `in_data`) is added into partial `i`. `in_count` has no effect on such a chunk.
- R3: On a chunk with `in_last` = 1, only lanes whose index is below `in_count` (0 to `LANES`) are added. The other lanes count as zero, and `in_count` = 0 adds nothing.
- R4: The edge that accepts a last chunk raises `busy`. `busy` stays high for exactly `log2(LANES)` cycles. `done` is high for exactly one cycle, the cycle in which `busy` has just fallen.
- R5: When `done` is 1, `sum_out` equals the wrapped 32-bit total of every lane included since reset or since the previous `done`.
- R6: `sum_out` changes only in a cycle where `done` is 1, and otherwise holds its value.
- R7: A chunk presented while `busy` is 1 is ignored and does not affect any result.
- R8: The partials are cleared as the result is taken, so the next stream starts from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A chunk is present on `in_data` |
| in_last | input | 1 | The present chunk ends the stream |
| in_count | input | 4 | Number of included lanes of a last chunk (0..LANES) |
| in_data | input | 256 | LANES words of 32 bits, lane 0 in the low bits |
| busy | output | 1 | Halving phase in progress; input is ignored |
| done | output | 1 | One-cycle pulse: `sum_out` holds a new result |
| sum_out | output | 32 | Result of the latest completed stream |

## Verification
The bench targets short last chunks, including a count of zero and a count of one. A masking fault there would let stale lanes of the bus into the total. Streams of all-ones words check that carries wrap rather than saturate. Garbage chunks held valid for the whole halving phase would corrupt the result, or restart a stream, in a design that does not gate input while busy. Back-to-back streams would carry old partials forward in a design that does not clear them, and a miscounted tree would be caught by a `done` that arrives at the wrong cycle or lasts too long.

// File: rtl/vr_pkg.sv
`timescale 1ns/1ps
package vr_pkg;

    typedef enum logic {
        PH_GATHER = 1'b0,
        PH_FOLD   = 1'b1
    } phase_e;

    typedef struct packed {
        logic take;    // chunk accepted this cycle
        logic fold;    // a halving step runs this cycle
        logic finish;  // this step is the final one
    } ctl_t;

    // active length after halving step 'step' (step 0 gives lanes/2)
    function automatic int half_len(input int lanes, input int step);
        return lanes >> (step + 1);
    endfunction

endpackage

// File: rtl/vr_lane_mask.sv
`timescale 1ns/1ps
module vr_lane_mask #(
    parameter int LANES = 8,
    parameter int DW    = 32,
    parameter int CW    = 4
) (
    input  logic [LANES*DW-1:0] data_i,
    input  logic                last_i,
    input  logic [CW-1:0]       count_i,
    output logic [LANES*DW-1:0] data_o
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam logic [CW-1:0] LANE_ID = CW'(i);
        logic keep;
        assign keep = !last_i || (LANE_ID < count_i);
        assign data_o[i*DW +: DW] = keep ? data_i[i*DW +: DW] : '0;
    end
endmodule

// File: rtl/vr_fold_step.sv
`timescale 1ns/1ps
module vr_fold_step import vr_pkg::*; #(
    parameter int LANES = 8,
    parameter int DW    = 32,
    parameter int SW    = 2
) (
    input  logic [LANES*DW-1:0] parts_i,
    input  logic [SW-1:0]       step_i,
    output logic [LANES*DW-1:0] parts_o
);
    localparam int AW = $clog2(LANES);

    logic [DW-1:0] pa [LANES];

    for (genvar i = 0; i < LANES; i++) begin : g_unpack
        assign pa[i] = parts_i[i*DW +: DW];
    end

    always_comb begin
        int h;
        h = half_len(LANES, int'(step_i));
        parts_o = '0;
        for (int j = 0; j < LANES; j++) begin
            if (j < h) begin
                parts_o[j*DW +: DW] = pa[AW'(j)] + pa[AW'(j + h)];
            end
        end
    end
endmodule

// File: rtl/vr_ctrl.sv
`timescale 1ns/1ps
module vr_ctrl import vr_pkg::*; #(
    parameter int STEPS = 3,
    parameter int SW    = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic          in_last,
    output ctl_t          ctl,
    output logic [SW-1:0] step,
    output logic          busy
);
    phase_e        ph_q, ph_d;
    logic [SW-1:0] step_q, step_d;

    always_comb begin
        ctl    = '0;
        ph_d   = ph_q;
        step_d = step_q;
        case (ph_q)
            PH_GATHER: begin
                ctl.take = in_valid;
                if (in_valid && in_last) begin
                    ph_d   = PH_FOLD;
                    step_d = '0;
                end
            end
            PH_FOLD: begin
                ctl.fold = 1'b1;
                if (step_q == SW'(STEPS - 1)) begin
                    ctl.finish = 1'b1;
                    ph_d       = PH_GATHER;
                    step_d     = '0;
                end else begin
                    step_d = step_q + 1'b1;
                end
            end
            default: ph_d = PH_GATHER;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q   <= PH_GATHER;
            step_q <= '0;
        end else begin
            ph_q   <= ph_d;
            step_q <= step_d;
        end
    end

    assign step = step_q;
    assign busy = (ph_q == PH_FOLD);
endmodule

// File: rtl/vec_reduce_unit.sv
`timescale 1ns/1ps
module vec_reduce_unit import vr_pkg::*; #(
    parameter int LANES = 8,
    parameter int DW    = 32,
    parameter int CW    = $clog2(LANES) + 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic                in_last,
    input  logic [CW-1:0]       in_count,
    input  logic [LANES*DW-1:0] in_data,
    output logic                busy,
    output logic                done,
    output logic [DW-1:0]       sum_out
);
    localparam int STEPS = $clog2(LANES);
    localparam int SW    = (STEPS > 1) ? $clog2(STEPS) : 1;

    ctl_t                ctl;
    logic [SW-1:0]       step;
    logic [LANES*DW-1:0] masked;
    logic [LANES*DW-1:0] accum;
    logic [LANES*DW-1:0] folded;
    logic [LANES*DW-1:0] parts_q;
    logic [DW-1:0]       sum_q;
    logic                done_q;

    vr_ctrl #(.STEPS(STEPS), .SW(SW)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_last  (in_last),
        .ctl      (ctl),
        .step     (step),
        .busy     (busy)
    );

    vr_lane_mask #(.LANES(LANES), .DW(DW), .CW(CW)) u_mask (
        .data_i  (in_data),
        .last_i  (in_last),
        .count_i (in_count),
        .data_o  (masked)
    );

    vr_fold_step #(.LANES(LANES), .DW(DW), .SW(SW)) u_fold (
        .parts_i (parts_q),
        .step_i  (step),
        .parts_o (folded)
    );

    // lane-wise accumulate: element i into partial i
    for (genvar i = 0; i < LANES; i++) begin : g_acc
        assign accum[i*DW +: DW] = parts_q[i*DW +: DW] + masked[i*DW +: DW];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            parts_q <= '0;
            sum_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= ctl.finish;
            if (ctl.take) begin
                parts_q <= accum;
            end else if (ctl.fold) begin
                if (ctl.finish) begin
                    sum_q   <= folded[DW-1:0];
                    parts_q <= '0;
                end else begin
                    parts_q <= folded;
                end
            end
        end
    end

    assign done    = done_q;
    assign sum_out = sum_q;
endmodule

// File: rtl/vr_reduce_chk.sv
`timescale 1ns/1ps
module vr_reduce_chk #(
    parameter int LANES = 8,
    parameter int DW    = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          in_valid,
    input logic          busy,
    input logic          done,
    input logic [DW-1:0] sum_out
);
    localparam int STEPS = $clog2(LANES);
    localparam int KW    = $clog2(STEPS + 2) + 1;

    logic [KW-1:0] busy_cycles;

    always_ff @(posedge clk) begin
        if (rst)       busy_cycles <= '0;
        else if (busy) busy_cycles <= busy_cycles + 1'b1;
        else           busy_cycles <= '0;
    end

    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!busy && !done && sum_out == '0));

    assert_done_latency_R4: assert property (@(posedge clk) disable iff (rst)
        done |-> (busy_cycles == KW'(STEPS)));

    assert_done_single_R4: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_busy_release_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    assert_busy_start_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(in_valid));

    assert_sum_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(sum_out));
endmodule

bind vec_reduce_unit vr_reduce_chk #(.LANES(LANES), .DW(DW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .busy     (busy),
    .done     (done),
    .sum_out  (sum_out)
);

// File: tb/sim_vec_reduce_unit.sv
`timescale 1ns/1ps
module sim_vec_reduce_unit;
    localparam int LANES = 8;
    localparam int DW    = 32;
    localparam int CW    = 4;
    localparam int STEPS = 3;

    logic                clk = 1'b0;
    logic                rst;
    logic                in_valid;
    logic                in_last;
    logic [CW-1:0]       in_count;
    logic [LANES*DW-1:0] in_data;
    logic                busy;
    logic                done;
    logic [DW-1:0]       sum_out;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  ended = 1'b0;
    logic [DW-1:0] exp_sum;

    always #2.5 clk = ~clk;

    vec_reduce_unit #(.LANES(LANES), .DW(DW), .CW(CW)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_last(in_last),
        .in_count(in_count), .in_data(in_data),
        .busy(busy), .done(done), .sum_out(sum_out)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] lane_word(input bit ones);
        return ones ? '1 : DW'($urandom());
    endfunction

    // reference: serial wrapped sum of included lanes
    function automatic logic [DW-1:0] chunk_total(input logic [LANES*DW-1:0] d,
                                                  input bit last, input int cnt);
        logic [DW-1:0] s = '0;
        for (int i = 0; i < LANES; i++)
            if (!last || i < cnt) s += d[i*DW +: DW];
        return s;
    endfunction

    // called at a negedge; returns at the negedge after acceptance
    task automatic send_chunk(input bit last, input int cnt, input bit ones);
        for (int i = 0; i < LANES; i++) in_data[i*DW +: DW] = lane_word(ones);
        in_valid = 1'b1;
        in_last  = last;
        in_count = CW'(cnt);
        exp_sum += chunk_total(in_data, last, cnt);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic run_stream(input int nchunks, input int last_cnt, input bit ones,
                              input bit junk, input string tag);
        int cyc;
        exp_sum = '0;
        for (int c = 0; c < nchunks - 1; c++) begin
            repeat ($urandom_range(0, 2)) @(negedge clk);
            // in_count is random on full chunks and must be ignored (R2)
            send_chunk(1'b0, $urandom_range(0, LANES), ones);
        end
        send_chunk(1'b1, last_cnt, ones);
        cyc = 1;
        if (junk) begin
            // garbage held valid through the halving phase (R7)
            for (int i = 0; i < LANES; i++) in_data[i*DW +: DW] = DW'($urandom());
            in_valid = 1'b1;
            in_last  = 1'b1;
            in_count = CW'(LANES);
        end
        check(busy == 1'b1, "R4 busy after last chunk", 32'(busy), 32'd1);
        while (!done && cyc < 20) begin
            @(negedge clk);
            cyc++;
        end
        in_valid = 1'b0;
        check(cyc == STEPS + 1, {"R4 done latency ", tag}, 32'(cyc), 32'(STEPS + 1));
        check(sum_out == exp_sum, {"R5 sum ", tag}, sum_out, exp_sum);
        @(negedge clk);
        check(done == 1'b0, "R4 done one cycle", 32'(done), 32'd0);
        check(sum_out == exp_sum, "R6 sum held", sum_out, exp_sum);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!ended) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            ended = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] held;
        void'($urandom(32'd4750));
        rst = 1'b1; in_valid = 1'b0; in_last = 1'b0; in_count = '0; in_data = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!busy && !done, "R1 reset flags", {30'd0, busy, done}, 32'd0);
        check(sum_out == '0, "R1 reset sum", sum_out, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !done && sum_out == '0, "R1 after reset", sum_out, 32'd0);

        run_stream(1, LANES, 1'b0, 1'b0, "R2 single full chunk");
        run_stream(3, 0, 1'b0, 1'b0, "R3 empty last chunk");
        run_stream(2, 1, 1'b0, 1'b0, "R3 last count one");
        run_stream(4, LANES, 1'b1, 1'b0, "R5 wrap all ones");
        run_stream(3, 5, 1'b0, 1'b1, "R7 junk while busy");
        // back-to-back stream must start from zero partials
        run_stream(1, 1, 1'b0, 1'b0, "R8 fresh partials");

        // idle: result must not move (R6)
        held = sum_out;
        repeat (5) @(negedge clk);
        check(sum_out == held, "R6 idle hold", sum_out, held);

        for (int k = 0; k < 20; k++) begin
            run_stream($urandom_range(1, 6), $urandom_range(0, LANES), 1'b0,
                       1'($urandom_range(0, 1)), "R5 random");
        end

        ended = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule